// File: doc/BRIEF.md
# Two-Stage Sampled Switch Debouncer

This block removes contact bounce from a single mechanical button or switch input. The raw input is first brought into the system clock domain by a two-flop synchronizer. A divider inside the block then produces a one-cycle sample enable every `tick_div + 1` system clocks. This enable stands in for a slow sampling clock of about 1 kHz, so all flops stay in the single system clock domain.

On each sample enable, a first-stage flop captures the synchronized level. On the same enable, a second-stage flop captures the AND of that captured value and the live synchronized level. The second stage drives the debounced output. The output therefore rises only when two consecutive samples both see the input high. It falls on the first sample that sees the input low.

A one-cycle pulse marks each rising edge of the debounced output. The sample period is set at run time through the `tick_div` input. It should be chosen longer than the worst bounce time of the contact.

Top module: `switch_debouncer`

## Requirements
- R1: While `rst` is high at a clock edge, `db_out` and `rise_pulse` are 0 after that edge.
- R2: The sample enable is high for one system clock at a time and repeats every `tick_div + 1` clocks. With P = `tick_div + 1`, an input that goes high and stays high drives `db_out` to 1 no later than 2P+3 clocks after the change.
- R3: `db_out` rises only when two consecutive samples both see the input high. After the input goes high, `db_out` is still 0 for at least P+2 clocks.
- R4: A high pulse on `raw_in` lasting fewer than P clocks, from an idle low state, leaves `db_out` at 0 and produces no `rise_pulse`.
- R5: When `db_out` is 1, the first sample that sees the input low clears it. If the input stays low, `db_out` is 0 no later than P+3 clocks after the change.
- R6: `rise_pulse` is high for exactly one clock on each 0-to-1 change of `db_out`. That clock is the first clock in which `db_out` is 1.
- R7: `raw_in` passes through two synchronizer flops. A change on `raw_in` leaves `db_out` unchanged for at least two clock edges.
- R8: A new `tick_div` value, applied during reset, sets the sample period. A short period (`tick_div` = 3) and a long period (`tick_div` = 19) both meet the bounds of R3 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_in | input | 1 | Asynchronous switch level |
| tick_div | input | DIV_W | Sample enable terminal count; period is tick_div+1 clocks |
| db_out | output | 1 | Debounced level |
| rise_pulse | output | 1 | One-cycle pulse on each rising edge of db_out |

## Verification
Every cycle, the assertions check four things:
- the reset clears the outputs;
- the second stage only moves on a sample enable;
- the enables stay apart for any divider above zero;
- `rise_pulse` is single-cycle and coincides with a fresh rise of `db_out`.

The timing windows in R2, R3 and R5 can only be shown by the bench's directed scenarios, as can the rejection of short glitches and the change of sample period. These scenarios measure `db_out` at fixed clock counts after each input change.

// File: rtl/switch_debouncer.sv
module switch_debouncer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw_in,
  input  logic [DIV_W-1:0] tick_div,
  output logic             db_out,
  output logic             rise_pulse
);

  logic             sync_a, sync_b;
  logic [DIV_W-1:0] div_cnt;
  logic             tick;
  logic             stage1, stage2, stage2_q;

  // two-flop synchronizer (R7)
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
    end else begin
      sync_a <= raw_in;
      sync_b <= sync_a;
    end
  end

  // slow sample enable (R2)
  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      tick    <= 1'b0;
    end else if (div_cnt >= tick_div) begin
      div_cnt <= '0;
      tick    <= 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
      tick    <= 1'b0;
    end
  end

  // two-sample agreement filter (R3, R5)
  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= 1'b0;
      stage2 <= 1'b0;
    end else if (tick) begin
      stage1 <= sync_b;
      stage2 <= stage1 & sync_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stage2_q <= 1'b0;
    else     stage2_q <= stage2;
  end

  assign db_out     = stage2;
  assign rise_pulse = stage2 & ~stage2_q;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!db_out && !rise_pulse));

  assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(stage2));

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && tick_div != '0) |=> !tick);

  assert_pulse_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    rise_pulse |=> !rise_pulse);

  assert_pulse_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
    rise_pulse |-> (db_out && !$past(db_out)));

  assert_rise_needs_high_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(db_out) |-> $past(stage1));

endmodule

// File: tb/switch_debouncer_tb.sv
module switch_debouncer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             raw_in = 1'b0;
  logic [DIV_W-1:0] tick_div = 16'd9;
  logic             db_out, rise_pulse;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  logic prev_out = 1'b0;
  logic prev_pulse = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  switch_debouncer #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst(rst), .raw_in(raw_in), .tick_div(tick_div),
    .db_out(db_out), .rise_pulse(rise_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse monitor (R6)
  always @(negedge clk) begin
    if (!rst) begin
      if (rise_pulse) begin
        pulses++;
        checks++;
        if (!db_out || prev_out || prev_pulse) begin
          errors++;
          $display("FAIL R6 pulse shape actual=%0d expected=%0d", {prev_pulse, prev_out, db_out}, 1);
        end
      end
    end
    prev_out   = db_out;
    prev_pulse = rise_pulse;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input int div);
    @(negedge clk);
    rst = 1'b1;
    raw_in = 1'b0;
    tick_div = DIV_W'(div);
    wait_n(3);
    rst = 1'b0;
    wait_n(2);
  endtask

  task automatic test_reset_R1();
    int p = int'(tick_div) + 1;
    raw_in = 1'b1;
    wait_n(2*p + 4);
    chk(db_out == 1'b1, "R1 pre-reset high", db_out, 1);
    rst = 1'b1;
    wait_n(1);
    chk(db_out == 1'b0, "R1 db_out in reset", db_out, 0);
    chk(rise_pulse == 1'b0, "R1 rise_pulse in reset", rise_pulse, 0);
    rst = 1'b0;
    raw_in = 1'b0;
    wait_n(2*p + 4);
  endtask

  task automatic test_rise_R2_R3(input string tag);
    int p = int'(tick_div) + 1;
    int start = pulses;
    raw_in = 1'b1;
    wait_n(p);
    chk(db_out == 1'b0, {"R3 still low after P ", tag}, db_out, 0);
    wait_n(p + 3);
    chk(db_out == 1'b1, {"R2 high by 2P+3 ", tag}, db_out, 1);
    chk(pulses - start == 1, {"R6 one pulse per rise ", tag}, pulses - start, 1);
  endtask

  task automatic test_fall_R5_R7(input string tag);
    int p = int'(tick_div) + 1;
    raw_in = 1'b0;
    wait_n(2);
    chk(db_out == 1'b1, {"R7 unchanged two edges ", tag}, db_out, 1);
    wait_n(p + 1);
    chk(db_out == 1'b0, {"R5 low by P+3 ", tag}, db_out, 0);
  endtask

  task automatic test_glitch_R4();
    int p = int'(tick_div) + 1;
    int start = pulses;
    for (int k = 0; k < 5; k++) begin
      raw_in = 1'b1;
      wait_n(p - 1);
      raw_in = 1'b0;
      wait_n(3*p);
      chk(db_out == 1'b0, "R4 short pulse rejected", db_out, 0);
    end
    chk(pulses == start, "R4 no rise_pulse", pulses - start, 0);
  endtask

  task automatic test_dropout_R5();
    int p = int'(tick_div) + 1;
    int start;
    raw_in = 1'b1;
    wait_n(2*p + 4);
    chk(db_out == 1'b1, "R5 settled high", db_out, 1);
    start = pulses;
    raw_in = 1'b0;
    wait_n(p + 3);
    chk(db_out == 1'b0, "R5 dropout clears output", db_out, 0);
    raw_in = 1'b1;
    wait_n(2*p + 4);
    chk(db_out == 1'b1, "R5 recovers high", db_out, 1);
    chk(pulses - start == 1, "R6 pulse after recovery", pulses - start, 1);
    raw_in = 1'b0;
    wait_n(p + 3);
  endtask

  initial begin
    wait_n(CLK_PERIOD * 0 + 1);
    chk(db_out == 1'b0 && rise_pulse == 1'b0, "R1 initial reset state", {db_out, rise_pulse}, 0);
    do_reset(9);
    test_rise_R2_R3("div9");
    test_fall_R5_R7("div9");
    test_glitch_R4();
    test_dropout_R5();
    test_reset_R1();
    do_reset(3);
    test_rise_R2_R3("R8 div3");
    test_fall_R5_R7("R8 div3");
    test_glitch_R4();
    do_reset(19);
    test_rise_R2_R3("R8 div19");
    test_fall_R5_R7("R8 div19");
    test_glitch_R4();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule